// File: doc/BRIEF.md
# Dual-Clock FIFO with Cycle-Exact Status Flags

This block carries data words from a write clock domain into a read clock domain that runs on an unrelated clock. Both sides keep a binary pointer one bit wider than the storage address. Each side turns its pointer into Gray code in a register and passes it across through a chain of flip-flops in the receiving domain. The chain depth can be set separately for each direction. A depth of one gives the lowest latency, but it protects against nothing and only suits clocks that are related.

Each domain sees full, empty and a used-word count of its own. Every one of these outputs changes a fixed number of clock cycles after the request that moved it, so logic around the FIFO can rely on those latencies. The used count has one bit more than the address, so it can report a completely full FIFO. A parameter selects the read data mode. In show-ahead mode the oldest stored word waits on the data output before it is requested. In the other mode a word appears one read clock after its request. A write request while full moves nothing, and neither does a read request while empty. Each domain has its own synchronous, active-high reset.

Top module: `dcf_fifo`

## Requirements
- R1: After both resets, the write side and the read side each show empty = 1, full = 0 and a used count of 0, and no side is ever full and empty at the same time.
- R2: A write accepted on write-clock edge k clears the write-side empty flag at edge k and raises the write-side used count at edge k+1.
- R3: A write accepted on write-clock edge k reaches the read-side empty and full flags on the n-th read-clock edge after write edge k+1, and the read-side used count one read edge later. Here n is the write-to-read synchronizer depth. A full FIFO sets the read-side full flag.
- R4: A read accepted on read-clock edge j updates the read-side empty and full flags at edge j and the read-side used count at edge j+1.
- R5: A read accepted on read-clock edge j reaches the write-side empty and full flags on the n-th write-clock edge after j, and the write-side used count one write edge later. Here n is the read-to-write synchronizer depth.
- R6: In show-ahead mode the data output presents the oldest unread word whenever the read side is not empty. A word written into an empty FIFO shows there one read edge after its write, and an accepted read presents the next word on the same read edge. Words leave in the order they were written.
- R7: After a number of writes equal to the depth with no reads, the write-side full flag is 1 and the write-side used count equals the depth. Further write requests change neither the count nor the stored words.
- R8: A read request while the read side is empty moves no pointer: the used count stays 0 and the next word written is still the one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| wr_req | input | 1 | Write request, accepted when not full |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | Write-side full flag |
| wr_empty | output | 1 | Write-side empty flag |
| wr_used | output | AW+1 | Write-side used-word count |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain synchronous reset, active high |
| rd_req | input | 1 | Read request, accepted when not empty |
| rd_data | output | DW | Read data (head word in show-ahead mode) |
| rd_full | output | 1 | Read-side full flag |
| rd_empty | output | 1 | Read-side empty flag |
| rd_used | output | AW+1 | Read-side used-word count |

## Verification
A single isolated write and then a single isolated read are timed edge by edge in both domains. This separates the local latency of each flag and count from its cross-domain latency, and it catches a synchronizer stage too many or too few. A burst that fills the FIFO and keeps requesting shows that writes stop at full, that both used counts reach the depth, and that no stored word is overwritten. Read requests on an empty FIFO, followed by one write, show that an empty read leaves no mark. A long stream with random gaps on both sides checks ordering and data integrity through the show-ahead output while pointers wrap many times.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef struct packed {
        logic full;
        logic empty;
    } dcf_flags_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

    // Compare an own pointer with a far pointer, both aw+1 bits wide.
    function automatic dcf_flags_t cmp_ptrs(input logic [31:0] own,
                                            input logic [31:0] far,
                                            input int aw);
        dcf_flags_t f;
        logic [31:0] d;
        d = (own ^ far) & ((32'd2 << aw) - 32'd1);
        f.full  = (d == (32'd1 << aw));
        f.empty = (d == 32'd0);
        return f;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_ptr_side.sv
module dcf_ptr_side
    import dcf_pkg::*;
#(
    parameter int AW        = 4,
    parameter bit IS_READER = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW:0]   far_gray,
    output logic [AW:0]   ptr,
    output logic [AW:0]   gray,
    output dcf_flags_t    flags,
    output logic [AW:0]   used,
    output logic          accept
);
    localparam int PW = AW + 1;

    logic [PW-1:0] far_bin;
    logic [PW-1:0] ptr_nxt;
    logic [PW-1:0] gray_src;

    assign far_bin = PW'(from_gray(32'(far_gray)));
    assign flags   = cmp_ptrs(32'(ptr), 32'(far_bin), AW);
    assign accept  = req && (IS_READER ? !flags.empty : !flags.full);
    assign ptr_nxt = ptr + PW'(accept);

    generate
        if (IS_READER) begin : g_rd
            // reader publishes its next pointer: crossing starts on the read edge
            assign gray_src = ptr_nxt;
        end else begin : g_wr
            // writer publishes its settled pointer: one extra write edge
            assign gray_src = ptr;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            gray <= '0;
            used <= '0;
        end else begin
            ptr  <= ptr_nxt;
            gray <= PW'(to_gray(32'(gray_src)));
            used <= IS_READER ? (far_bin - ptr) : (ptr - far_bin);
        end
    end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 4,
    parameter int W2R_STAGES = 2,
    parameter int R2W_STAGES = 2,
    parameter bit SHOW_AHEAD = 1'b1
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    output logic          wr_empty,
    output logic [AW:0]   wr_used,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_full,
    output logic          rd_empty,
    output logic [AW:0]   rd_used
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    logic [AW:0] wr_ptr, wr_gray, wr_gray_at_rd;
    logic [AW:0] rd_ptr, rd_gray, rd_gray_at_wr;
    dcf_flags_t  wr_flags, rd_flags;
    logic        wr_accept, rd_accept;

    dcf_ptr_side #(.AW(AW), .IS_READER(1'b0)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .req(wr_req), .far_gray(rd_gray_at_wr),
        .ptr(wr_ptr), .gray(wr_gray), .flags(wr_flags), .used(wr_used),
        .accept(wr_accept)
    );

    dcf_ptr_side #(.AW(AW), .IS_READER(1'b1)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .req(rd_req), .far_gray(wr_gray_at_rd),
        .ptr(rd_ptr), .gray(rd_gray), .flags(rd_flags), .used(rd_used),
        .accept(rd_accept)
    );

    dcf_sync #(.W(AW+1), .STAGES(W2R_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_at_rd)
    );

    dcf_sync #(.W(AW+1), .STAGES(R2W_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_at_wr)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_accept) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    generate
        if (SHOW_AHEAD) begin : g_show_ahead
            logic [AW-1:0] head_addr;
            assign head_addr = rd_ptr[AW-1:0] + AW'(rd_accept);
            always_ff @(posedge rd_clk) begin
                if (rd_rst) rd_data <= '0;
                else        rd_data <= mem[head_addr];
            end
        end else begin : g_normal
            always_ff @(posedge rd_clk) begin
                if (rd_rst)         rd_data <= '0;
                else if (rd_accept) rd_data <= mem[rd_ptr[AW-1:0]];
            end
        end
    endgenerate

    assign wr_full  = wr_flags.full;
    assign wr_empty = wr_flags.empty;
    assign rd_full  = rd_flags.full;
    assign rd_empty = rd_flags.empty;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int AW = 4
) (
    input logic        wr_clk,
    input logic        wr_rst,
    input logic        rd_clk,
    input logic        rd_rst,
    input logic        wr_req,
    input logic        rd_req,
    input logic        wr_full,
    input logic        wr_empty,
    input logic        rd_full,
    input logic        rd_empty,
    input logic [AW:0] wr_used,
    input logic [AW:0] wr_ptr,
    input logic [AW:0] rd_ptr,
    input logic [AW:0] wr_gray
);
    localparam int DEPTH = 1 << AW;

    p_wr_flags_excl_r1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !(wr_full && wr_empty));

    p_rd_flags_excl_r1: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_full && rd_empty));

    p_wr_step_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_req && !wr_full) |=> (wr_ptr == (AW+1)'($past(wr_ptr) + 1'b1)));

    p_gray_one_bit_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_req && wr_full) |=> $stable(wr_ptr));

    p_used_bound_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_used <= (AW+1)'(DEPTH));

    p_no_underflow_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_req && rd_empty) |=> $stable(rd_ptr));
endmodule

bind dcf_fifo dcf_fifo_chk #(.AW(AW)) u_chk (.*);

// File: tb/dcf_fifo_test.sv
`timescale 1ns/100ps
module dcf_fifo_test;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NW2R  = 2;
    localparam int NR2W  = 2;

    logic          wr_clk, wr_rst, wr_req;
    logic [DW-1:0] wr_data;
    logic          wr_full, wr_empty;
    logic [AW:0]   wr_used;
    logic          rd_clk, rd_rst, rd_req;
    logic [DW-1:0] rd_data;
    logic          rd_full, rd_empty;
    logic [AW:0]   rd_used;

    dcf_fifo #(.DW(DW), .AW(AW), .W2R_STAGES(NW2R), .R2W_STAGES(NR2W),
               .SHOW_AHEAD(1'b1)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_req(wr_req), .wr_data(wr_data),
        .wr_full(wr_full), .wr_empty(wr_empty), .wr_used(wr_used),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(rd_req), .rd_data(rd_data),
        .rd_full(rd_full), .rd_empty(rd_empty), .rd_used(rd_used)
    );

    initial wr_clk = 1'b0;
    always #4 wr_clk = ~wr_clk;          // 125 MHz write clock

    initial begin                        // unrelated read clock, never aligned
        rd_clk = 1'b0;
        #1.3;
        forever #5.2 rd_clk = ~rd_clk;
    end

    int            checks = 0;
    int            fails  = 0;
    bit            rd_auto = 1'b0;
    logic [DW-1:0] sb [$];

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops and compares the head word on each accepted read
    initial begin
        forever begin
            @(negedge rd_clk);
            if (rd_auto) begin
                if (!rd_empty && ($urandom % 4) != 0) begin
                    if (sb.size() == 0) check_eq("R6 unexpected word", int'(rd_data), -1);
                    else                check_eq("R6 order/data", int'(rd_data), int'(sb.pop_front()));
                    rd_req = 1'b1;
                end else begin
                    rd_req = 1'b0;
                end
            end
        end
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic drain_and_check(input string req);
        int guard = 0;
        while (sb.size() != 0 && guard < 20000) begin
            @(negedge rd_clk);
            guard++;
        end
        check_eq(req, sb.size(), 0);
    endtask

    initial begin
        wr_rst = 1'b1; rd_rst = 1'b1;
        wr_req = 1'b0; rd_req = 1'b0; wr_data = '0;
        repeat (5) @(posedge wr_clk);
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge rd_clk) rd_rst = 1'b0;
        repeat (3) @(negedge wr_clk);

        // R1: reset state
        check_eq("R1 wr_full",  wr_full,  0);
        check_eq("R1 wr_empty", wr_empty, 1);
        check_eq("R1 wr_used",  wr_used,  0);
        check_eq("R1 rd_full",  rd_full,  0);
        check_eq("R1 rd_empty", rd_empty, 1);
        check_eq("R1 rd_used",  rd_used,  0);

        // R2 / R3: one isolated write
        @(negedge wr_clk);
        wr_req = 1'b1; wr_data = 8'hA5;
        @(posedge wr_clk);                       // edge k
        #1 wr_req = 1'b0;
        check_eq("R2 wr_empty at k", wr_empty, 0);
        check_eq("R2 wr_used at k",  wr_used,  0);
        @(posedge wr_clk);                       // edge k+1
        fork
            begin
                #1 check_eq("R2 wr_used at k+1", wr_used, 1);
            end
            begin
                repeat (NW2R - 1) @(posedge rd_clk);
                #1 check_eq("R3 rd_empty before n", rd_empty, 1);
                @(posedge rd_clk);
                #1 check_eq("R3 rd_empty at n", rd_empty, 0);
                check_eq("R3 rd_used at n", rd_used, 0);
                check_eq("R6 show-ahead head", int'(rd_data), 8'hA5);
                @(posedge rd_clk);
                #1 check_eq("R3 rd_used at n+1", rd_used, 1);
            end
        join

        // R4 / R5: one isolated read
        @(negedge rd_clk);
        rd_req = 1'b1;
        @(posedge rd_clk);                       // edge j
        fork
            begin
                #1 rd_req = 1'b0;
                check_eq("R4 rd_empty at j", rd_empty, 1);
                check_eq("R4 rd_used at j",  rd_used,  1);
                @(posedge rd_clk);
                #1 check_eq("R4 rd_used at j+1", rd_used, 0);
            end
            begin
                repeat (NR2W - 1) @(posedge wr_clk);
                #1 check_eq("R5 wr_empty before n", wr_empty, 0);
                @(posedge wr_clk);
                #1 check_eq("R5 wr_empty at n", wr_empty, 1);
                check_eq("R5 wr_used at n", wr_used, 1);
                @(posedge wr_clk);
                #1 check_eq("R5 wr_used at n+1", wr_used, 0);
            end
        join

        // R8: reads while empty leave no mark
        repeat (3) begin
            @(negedge rd_clk);
            rd_req = 1'b1;
        end
        @(negedge rd_clk);
        rd_req = 1'b0;
        repeat (4) @(negedge rd_clk);
        check_eq("R8 rd_used after empty reads",  rd_used,  0);
        check_eq("R8 rd_empty after empty reads", rd_empty, 1);
        @(negedge wr_clk);
        wr_req = 1'b1; wr_data = 8'h3C;
        @(negedge wr_clk);
        wr_req = 1'b0;
        repeat (8) @(negedge rd_clk);
        check_eq("R8 rd_used after write", rd_used, 1);
        check_eq("R8 next word delivered", int'(rd_data), 8'h3C);
        @(negedge rd_clk) rd_req = 1'b1;
        @(negedge rd_clk) rd_req = 1'b0;
        repeat (8) @(negedge wr_clk);
        check_eq("R5 wr_empty after drain", wr_empty, 1);

        // R7: fill to depth, then keep requesting
        @(negedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            wr_req  = 1'b1;
            wr_data = 8'(8'h40 + i);
            sb.push_back(wr_data);
            @(negedge wr_clk);
        end
        check_eq("R7 wr_full after depth writes", wr_full, 1);
        wr_data = 8'hEE;
        @(negedge wr_clk);
        check_eq("R7 wr_used equals depth", wr_used, DEPTH);
        repeat (2) @(negedge wr_clk);
        wr_req = 1'b0;
        @(negedge wr_clk);
        check_eq("R7 wr_used unchanged by extra writes", wr_used, DEPTH);
        check_eq("R7 wr_full held", wr_full, 1);
        repeat (8) @(negedge rd_clk);
        check_eq("R3 rd_full when full", rd_full, 1);
        check_eq("R7 rd_used equals depth", rd_used, DEPTH);
        rd_auto = 1'b1;
        drain_and_check("R7 all stored words delivered");
        repeat (10) @(negedge rd_clk);
        check_eq("R7 no extra word stored", rd_empty, 1);

        // R6: long random stream in both domains
        begin
            int sent = 0;
            while (sent < 300) begin
                @(negedge wr_clk);
                if (!wr_full && ($urandom % 3) != 0) begin
                    wr_req  = 1'b1;
                    wr_data = 8'($urandom);
                    sb.push_back(wr_data);
                    sent++;
                end else begin
                    wr_req = 1'b0;
                end
            end
            @(negedge wr_clk);
            wr_req = 1'b0;
        end
        drain_and_check("R6 stream drained");
        repeat (10) @(negedge rd_clk);
        check_eq("R6 rd_empty after stream", rd_empty, 1);
        check_eq("R6 rd_used after stream",  rd_used,  0);
        rd_auto = 1'b0;
        rd_req  = 1'b0;
        repeat (8) @(negedge wr_clk);
        check_eq("R5 wr_empty after stream", wr_empty, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule